// File: doc/BRIEF.md
# Time-of-Day Counter with Update Hold

This block keeps the time of day in three byte-wide registers (seconds, minutes, hours). It advances them by one second whenever a one-cycle tick strobe arrives from an external divider. A host reaches the three time registers and one control register through a simple address/data port. Writes are taken on the clock edge. Reads are combinational from the address.

The control register has two bits. The hold bit freezes the advance, so software can load a new time without a tick landing halfway through the load. The binary bit picks how all three registers count. When it is set, they count in plain binary. When it is clear, they count in packed BCD, where each nibble is a decimal digit. Each completed advance raises a one-cycle update-done pulse.

Top module: `rtc_time_core`

## Requirements
- R1: After reset, the seconds, minutes and hours registers read 0 and upd_done is 0.
- R2: A write with wr_en high loads wdata into the register at addr: 0 is seconds, 1 is minutes, 2 is hours and 3 is control. rdata always shows the register at addr. In control, bit 0 is hold, bit 1 is binary mode and bits 7..2 read 0.
- R3: A tick with hold at 0 and no write in the same cycle adds one to seconds on that clock edge. In binary mode the value counts in plain binary, and in BCD mode it counts in packed BCD.
- R4: Seconds and minutes wrap from 59 to 0 and carry one into the next field. Hours wrap from 23 to 0. The wrap values are 59/23 in binary mode and 0x59/0x23 in BCD mode.
- R5: In BCD mode, a low nibble of 9 becomes 0 and the high nibble goes up by one, for example 0x09 becomes 0x10 and 0x39 becomes 0x40.
- R6: While hold is 1, ticks change no time register and produce no upd_done pulse. Host writes are still taken.
- R7: upd_done is high for exactly the one cycle after an accepted tick, which is the same cycle the new time first shows on rdata. It is low at all other times.
- R8: When wr_en and tick are both high in the same cycle, the write is taken. That tick is discarded and gives no upd_done pulse.
- R9: Neither reset nor counting changes the hold and binary bits. Only a host write to address 3 changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the time registers |
| tick | input | 1 | One-cycle once-per-second strobe |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for addr |
| upd_done | output | 1 | One-cycle pulse after each completed advance |

## Verification
The bench builds the block with its default 8-bit data and 2-bit address. In both counting modes, it loads every hour and minute pair with seconds at 58 and then ticks twice, so every minute and hour carry and the midnight wrap are exercised. It also runs more than an hour of ticks without a break through midnight. The expected time is worked out from a seconds-of-day integer and encoded with division and remainder. The bench also tests hold, a write and a tick in the same cycle, and whether the control bits survive reset.

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          upd_done
);
  localparam logic [AW-1:0] A_SEC = AW'(0);
  localparam logic [AW-1:0] A_MIN = AW'(1);
  localparam logic [AW-1:0] A_HR  = AW'(2);
  localparam logic [AW-1:0] A_CTL = AW'(3);

  logic [DW-1:0] sec, min, hr;
  logic          hold, bin;
  logic          accepted;
  logic [DW:0]   sec_n, min_n, hr_n;
  logic [DW-1:0] lim_ms, lim_h;

  function automatic logic [DW:0] step(input logic [DW-1:0] v, input logic [DW-1:0] lim,
                                       input logic b);
    if (v >= lim)
      step = {1'b1, {DW{1'b0}}};
    else if (!b && v[3:0] >= 4'd9)
      step = {1'b0, v[DW-1:4] + 1'b1, 4'd0};
    else
      step = {1'b0, v + 1'b1};
  endfunction

  assign accepted = tick & ~hold & ~wr_en;
  assign lim_ms   = bin ? DW'(59) : DW'(8'h59);
  assign lim_h    = bin ? DW'(23) : DW'(8'h23);
  assign sec_n    = step(sec, lim_ms, bin);
  assign min_n    = step(min, lim_ms, bin);
  assign hr_n     = step(hr,  lim_h,  bin);

  always_ff @(posedge clk)
    if (wr_en && addr == A_CTL) begin
      hold <= wdata[0];
      bin  <= wdata[1];
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec      <= '0;
      min      <= '0;
      hr       <= '0;
      upd_done <= 1'b0;
    end else begin
      upd_done <= accepted;
      if (wr_en) begin
        case (addr)
          A_SEC:   sec <= wdata;
          A_MIN:   min <= wdata;
          A_HR:    hr  <= wdata;
          default: ;
        endcase
      end else if (accepted) begin
        sec <= sec_n[DW-1:0];
        if (sec_n[DW]) min <= min_n[DW-1:0];
        if (sec_n[DW] && min_n[DW]) hr <= hr_n[DW-1:0];
      end
    end
  end

  always_comb
    case (addr)
      A_SEC:   rdata = sec;
      A_MIN:   rdata = min;
      A_HR:    rdata = hr;
      default: rdata = {{(DW-2){1'b0}}, bin, hold};
    endcase
endmodule

module rtc_time_core_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          hold,
  input logic          bin,
  input logic [DW-1:0] sec,
  input logic [DW-1:0] min,
  input logic [DW-1:0] hr,
  input logic          upd_done
);
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(tick) && !$past(hold) && !$past(wr_en));

  assert_pulse_follows_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !hold && !wr_en |=> upd_done);

  assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !wr_en |=> $stable(sec) && $stable(min) && $stable(hr) && !upd_done);

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(0) |=> sec == $past(wdata) && !upd_done);

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !hold && !wr_en && sec == (bin ? DW'(59) : DW'(8'h59)) |=> sec == '0);

  assert_ctrl_kept_R9: assert property (@(posedge clk)
    !(wr_en && addr == AW'(3)) |=> $stable(hold) && $stable(bin));
endmodule

bind rtc_time_core rtc_time_core_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/rtc_time_core_bench.sv
`timescale 1ns/1ps
module rtc_time_core_bench;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic upd_done;
  int checks = 0, fails = 0;

  rtc_time_core u_rtc_time_core (.clk, .rst_n, .tick, .wr_en, .addr, .wdata, .rdata, .upd_done);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] enc(int v, bit b);
    return b ? 8'(v) : 8'((v / 10) * 16 + v % 10);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic do_tick(output logic pulse);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; pulse = upd_done;
  endtask

  task automatic chk_time(string tag, int t, bit b);
    logic [7:0] d;
    rd(0, d); chk(tag, d, enc(t % 60, b));
    rd(1, d); chk(tag, d, enc((t / 60) % 60, b));
    rd(2, d); chk(tag, d, enc(t / 3600, b));
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic p;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_time("R1 reset", 0, 1'b0);
    chk("R1 upd", {7'b0, upd_done}, 8'h00);
    wr(3, 8'h00);
    rd(3, d); chk("R2 ctrl", d, 8'h00);

    for (int m = 0; m < 2; m++) begin
      bit b = (m == 1);
      wr(3, {6'b0, b, 1'b0});
      rd(3, d); chk("R2 ctrl rd", d, {6'b0, b, 1'b0});
      for (int h = 0; h < 24; h++)
        for (int mi = 0; mi < 60; mi++) begin
          t = h * 3600 + mi * 60 + 58;
          wr(0, enc(58, b)); wr(1, enc(mi, b)); wr(2, enc(h, b));
          do_tick(p); chk("R7 pulse", {7'b0, p}, 8'h01);
          chk_time("R3 step", t + 1, b);
          do_tick(p);
          chk_time("R4 carry", (t + 2) % 86400, b);
          @(negedge clk); chk("R7 one cycle", {7'b0, upd_done}, 8'h00);
        end
      wr(0, 0); wr(1, 0); wr(2, enc(23, b));
      t = 23 * 3600;
      for (int k = 0; k < 3700; k++) begin
        do_tick(p);
        t = (t + 1) % 86400;
        rd(0, d); chk("R5 run sec", d, enc(t % 60, b));
      end
      chk_time("R4 midnight", t, b);

      wr(3, {6'b0, b, 1'b1});
      do_tick(p); chk("R6 no pulse", {7'b0, p}, 8'h00);
      chk_time("R6 frozen", t, b);
      wr(1, enc(42, b));
      t = (t % 60) + 42 * 60 + (t / 3600) * 3600;
      chk_time("R6 write in hold", t, b);
      wr(3, {6'b0, b, 1'b0});

      @(negedge clk); wr_en = 1; tick = 1; addr = 0; wdata = enc(30, b);
      @(negedge clk); wr_en = 0; tick = 0;
      chk("R8 no pulse", {7'b0, upd_done}, 8'h00);
      rd(0, d); chk("R8 write wins", d, enc(30, b));
    end

    wr(3, 8'h03);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(3, d); chk("R9 ctrl after reset", d, 8'h03);
    chk_time("R1 second reset", 0, 1'b1);
    wr(3, 8'h02);
    do_tick(p);
    rd(3, d); chk("R9 ctrl after tick", d, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule